// File: doc/BRIEF.md
# Programmable Trigger Line Router

This block manages two general-purpose digital lines that can each either receive an external timing signal or drive one of several internal timing signals. Each line has its own direction and its own output source selection. A line set to input can feed the start trigger, the stop trigger or the sample clock. A line set to output can drive any of these: a start or stop trigger pulse, an end-of-acquisition pulse, the sample clock, the analog trigger comparator output, a frequency generator output, a constant low or a constant high.

Trigger events are stretched to a fixed width in the timebase clock domain. The end-of-acquisition request is stretched to a fixed number of sample-clock periods. The sample-clock periods are counted through rising edges of the selected sample clock, detected in the timebase domain. The block holds its configuration in registers that load on a single strobe. After reset both lines are inputs and the backplane sample-clock copy is off. The comparator, the frequency generator and the acquisition sequencer sit outside the block; only their digital outputs enter it.

Top module: `trig_line_router`

## Requirements
- R1: Each line drives (line_oe high) only when its direction bit is 1. After reset both direction bits are 0, so line_oe is 0.
- R2: For a line that drives, line_out follows its 3-bit source code: 0 low, 1 high, 2 start pulse, 3 stop pulse, 4 end-of-acquisition pulse, 5 sample clock, 6 analog comparator (ana_cmp), 7 frequency input (freq_in). A line that does not drive shows 0 on line_out.
- R3: The start select code picks the start event source: 0 the sw_start request, 1 a rising edge of ana_cmp, 2 or 3 a rising edge on line 0 or line 1. A line counts only while it is an input, and its input passes a two-flop synchronizer. Each event makes start_pulse high for exactly TRIG_CYC (2) clocks, starting on the edge that samples the event.
- R4: The stop select code works like the start select and gives the same pulse width. Code 0 is rejected, so sw_start never causes a stop pulse.
- R5: An event that arrives while a start or stop pulse is still high is dropped and does not extend the pulse.
- R6: When eoa_req is sampled high on a clock with a sample-clock rising edge, eoa_pulse goes high and stays high for EOA_PER (2) sample-clock periods. Later requests are dropped while it is high.
- R7: The sample clock select code picks the source for samp_clk: 0 or 1 int_sclk, 2 or 3 the synchronized input of line 0 or line 1. A line driven with code 5 shows a constant high while the sample-clock enable bit is 0.
- R8: bp_sclk copies samp_clk only while the backplane enable bit is set. This bit is 0 after reset.
- R9: The configuration inputs take effect only on a clock where cfg_load is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Loads all configuration inputs |
| cfg_dir | input | NLINES | Direction per line, 1 = drive |
| cfg_osel | input | 3*NLINES | Output source code per line, line i at bits 3i+2:3i |
| cfg_start_sel | input | SEL_W | Start event source code |
| cfg_stop_sel | input | SEL_W | Stop event source code |
| cfg_sclk_sel | input | SEL_W | Sample clock source code |
| cfg_sclk_en | input | 1 | Sample clock allowed onto a line |
| cfg_bp_en | input | 1 | Backplane sample clock copy enable |
| sw_start | input | 1 | Software start request |
| ana_cmp | input | 1 | Analog comparator output |
| freq_in | input | 1 | Frequency generator output |
| int_sclk | input | 1 | Internal sample clock |
| eoa_req | input | 1 | End-of-acquisition request |
| line_in | input | NLINES | Pad input value per line |
| line_oe | output | NLINES | Pad drive enable per line |
| line_out | output | NLINES | Pad output value per line |
| start_pulse | output | 1 | Stretched start trigger |
| stop_pulse | output | 1 | Stretched stop trigger |
| eoa_pulse | output | 1 | Stretched end-of-acquisition |
| samp_clk | output | 1 | Selected sample clock |
| bp_sclk | output | 1 | Backplane sample clock copy |

## Verification
Start and stop pulses rise on the first edge after a software or comparator event. For a line-input event they rise on the third edge: two synchronizer stages, then the edge sampler. eoa_pulse rises on the edge that sees a sample-clock rising edge together with the request. samp_clk, bp_sclk and line_out follow their combinational sources within the same cycle. The bench changes inputs just after a rising edge and updates its reference model on each rising edge from the values that edge samples. It compares every output at the following falling edge, so each result is checked in the cycle it is due.

// File: rtl/trl_pkg.sv
// Shared types for the trigger line router: output source codes.
package trl_pkg;
    typedef enum logic [2:0] {
        OSRC_LOW   = 3'd0,
        OSRC_HIGH  = 3'd1,
        OSRC_START = 3'd2,
        OSRC_STOP  = 3'd3,
        OSRC_EOA   = 3'd4,
        OSRC_SCLK  = 3'd5,
        OSRC_ANA   = 3'd6,
        OSRC_FREQ  = 3'd7
    } osrc_e;
endpackage

// File: rtl/line_sync.sv
// Synchronizes one pad input into the clk domain and detects rising edges.
// Assumes: pin is asynchronous; the output is gated to 0 while the line drives.
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic is_input,
    output logic rx,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              prev;

    // Shift the pad value through the synchronizer and keep the last stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], pin};
            prev <= sh[STAGES-1];
        end
    end

    assign rx   = is_input & sh[STAGES-1];
    assign rise = is_input & sh[STAGES-1] & ~prev;
endmodule

// File: rtl/pulse_stretch.sv
// Stretches a one-cycle trigger into a high level lasting LEN ticks.
// Assumes: trig is sampled only while idle; triggers during a pulse are dropped.
module pulse_stretch #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trig,
    output logic pulse
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [CW-1:0] cnt;

    // Start on an idle trigger, count ticks while high, drop after LEN ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            cnt   <= '0;
        end else if (!pulse) begin
            if (trig) begin
                pulse <= 1'b1;
                cnt   <= '0;
            end
        end else if (tick) begin
            if (cnt == CW'(LEN - 1)) pulse <= 1'b0;
            else                     cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/line_drv.sv
// Output multiplexer for one line: picks the source and applies direction.
// Assumes: all sources are already in the clk domain or are pass-through levels.
module line_drv
    import trl_pkg::*;
(
    input  logic       drive,
    input  logic [2:0] osel,
    input  logic       start_p,
    input  logic       stop_p,
    input  logic       eoa_p,
    input  logic       sclk_line,
    input  logic       ana,
    input  logic       freq,
    output logic       oe,
    output logic       dout
);
    logic val;

    // Select the value the line would carry when driving.
    always_comb begin
        unique case (osrc_e'(osel))
            OSRC_LOW:   val = 1'b0;
            OSRC_HIGH:  val = 1'b1;
            OSRC_START: val = start_p;
            OSRC_STOP:  val = stop_p;
            OSRC_EOA:   val = eoa_p;
            OSRC_SCLK:  val = sclk_line;
            OSRC_ANA:   val = ana;
            OSRC_FREQ:  val = freq;
            default:    val = 1'b0;
        endcase
    end

    assign oe   = drive;
    assign dout = drive & val;
endmodule

// File: rtl/trig_line_router.sv
// Top of the trigger line router: configuration registers, event source
// selection, sample clock selection, pulse stretchers and per-line drivers.
// Assumes: clk is the timebase; int_sclk, ana_cmp, freq_in, sw_start and
// eoa_req are already synchronous to clk; line_in is asynchronous.
module trig_line_router #(
    parameter int NLINES      = 2,
    parameter int TRIG_CYC    = 2,
    parameter int EOA_PER     = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NLINES + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic [NLINES-1:0]     cfg_dir,
    input  logic [3*NLINES-1:0]   cfg_osel,
    input  logic [SEL_W-1:0]      cfg_start_sel,
    input  logic [SEL_W-1:0]      cfg_stop_sel,
    input  logic [SEL_W-1:0]      cfg_sclk_sel,
    input  logic                  cfg_sclk_en,
    input  logic                  cfg_bp_en,
    input  logic                  sw_start,
    input  logic                  ana_cmp,
    input  logic                  freq_in,
    input  logic                  int_sclk,
    input  logic                  eoa_req,
    input  logic [NLINES-1:0]     line_in,
    output logic [NLINES-1:0]     line_oe,
    output logic [NLINES-1:0]     line_out,
    output logic                  start_pulse,
    output logic                  stop_pulse,
    output logic                  eoa_pulse,
    output logic                  samp_clk,
    output logic                  bp_sclk
);
    logic [NLINES-1:0] dir_q;
    logic [2:0]        osel_q [NLINES];
    logic [SEL_W-1:0]  start_sel_q, stop_sel_q, sclk_sel_q;
    logic              sclk_en_q, bp_en_q;

    logic [NLINES-1:0] line_rx, line_rise;
    logic              ana_q, ana_rise;
    logic              start_ev, stop_ev;
    logic              sclk_sel, sclk_prev, samp_rise;
    logic              sclk_line;

    // Hold the configuration; load it only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q       <= '0;
            start_sel_q <= '0;
            stop_sel_q  <= '0;
            sclk_sel_q  <= '0;
            sclk_en_q   <= 1'b0;
            bp_en_q     <= 1'b0;
            for (int i = 0; i < NLINES; i++) osel_q[i] <= '0;
        end else if (cfg_load) begin
            dir_q       <= cfg_dir;
            start_sel_q <= cfg_start_sel;
            stop_sel_q  <= cfg_stop_sel;
            sclk_sel_q  <= cfg_sclk_sel;
            sclk_en_q   <= cfg_sclk_en;
            bp_en_q     <= cfg_bp_en;
            for (int i = 0; i < NLINES; i++) osel_q[i] <= cfg_osel[3*i +: 3];
        end
    end

    // Remember the comparator level and the selected sample clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ana_q     <= 1'b0;
            sclk_prev <= 1'b0;
        end else begin
            ana_q     <= ana_cmp;
            sclk_prev <= sclk_sel;
        end
    end

    assign ana_rise  = ana_cmp & ~ana_q;
    assign samp_rise = sclk_sel & ~sclk_prev;

    // Route the selected sources to the start and stop events and the sample clock.
    always_comb begin
        start_ev = 1'b0;
        stop_ev  = 1'b0;
        sclk_sel = int_sclk;
        if (start_sel_q == SEL_W'(0)) start_ev = sw_start;
        if (start_sel_q == SEL_W'(1)) start_ev = ana_rise;
        if (stop_sel_q  == SEL_W'(1)) stop_ev  = ana_rise;
        for (int i = 0; i < NLINES; i++) begin
            if (start_sel_q == SEL_W'(i + 2)) start_ev = line_rise[i];
            if (stop_sel_q  == SEL_W'(i + 2)) stop_ev  = line_rise[i];
            if (sclk_sel_q  == SEL_W'(i + 2)) sclk_sel = line_rx[i];
        end
    end

    assign samp_clk  = sclk_sel;
    assign bp_sclk   = bp_en_q & sclk_sel;
    assign sclk_line = sclk_en_q ? sclk_sel : 1'b1;

    pulse_stretch #(.LEN(TRIG_CYC)) u_start (
        .clk(clk), .rst_n(rst_n), .tick(1'b1), .trig(start_ev), .pulse(start_pulse)
    );
    pulse_stretch #(.LEN(TRIG_CYC)) u_stop (
        .clk(clk), .rst_n(rst_n), .tick(1'b1), .trig(stop_ev), .pulse(stop_pulse)
    );
    pulse_stretch #(.LEN(EOA_PER)) u_eoa (
        .clk(clk), .rst_n(rst_n), .tick(samp_rise), .trig(eoa_req & samp_rise),
        .pulse(eoa_pulse)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin(line_in[g]), .is_input(~dir_q[g]),
            .rx(line_rx[g]), .rise(line_rise[g])
        );
        line_drv u_drv (
            .drive(dir_q[g]), .osel(osel_q[g]), .start_p(start_pulse),
            .stop_p(stop_pulse), .eoa_p(eoa_pulse), .sclk_line(sclk_line),
            .ana(ana_cmp), .freq(freq_in), .oe(line_oe[g]), .dout(line_out[g])
        );
    end
endmodule

// File: rtl/trl_checker.sv
// Property checker for the trigger line router, attached by bind.
// Assumes: synchronous active-low reset on clk.
module trl_checker #(
    parameter int NLINES   = 2,
    parameter int SEL_W    = 2,
    parameter int TRIG_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic [NLINES-1:0] line_oe,
    input logic              start_pulse,
    input logic              stop_pulse,
    input logic              eoa_pulse,
    input logic [SEL_W-1:0]  stop_sel,
    input logic              samp_rise
);
    logic [7:0] start_run, stop_run;

    // Count how many sampled cycles each trigger pulse has been high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_run <= '0;
            stop_run  <= '0;
        end else begin
            start_run <= start_pulse ? start_run + 8'd1 : 8'd0;
            stop_run  <= stop_pulse  ? stop_run  + 8'd1 : 8'd0;
        end
    end

    // R3 and R5: start pulse is exactly TRIG_CYC cycles, never extended
    p_start_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_pulse) |-> start_run == 8'(TRIG_CYC));

    // R4 and R5: stop pulse is exactly TRIG_CYC cycles
    p_stop_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_pulse) |-> stop_run == 8'(TRIG_CYC));

    // R4: software code never starts a stop pulse
    p_stop_no_sw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_pulse) |-> $past(stop_sel) != '0);

    // R6: end-of-acquisition starts only on a sample clock rising edge
    p_eoa_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoa_pulse) |-> $past(samp_rise));

    // R9 and R1: line directions change only after a load strobe
    p_oe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_load) |-> $stable(line_oe));
endmodule

bind trig_line_router trl_checker #(
    .NLINES(NLINES), .SEL_W(SEL_W), .TRIG_CYC(TRIG_CYC)
) u_trl_chk (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .line_oe(line_oe),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .eoa_pulse(eoa_pulse),
    .stop_sel(stop_sel_q), .samp_rise(samp_rise)
);

// File: tb/tb_trig_line_router.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module tb_trig_line_router;
    localparam int TRIG = 2;
    localparam int EOAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 0;
    logic [1:0] cfg_dir = 0;
    logic [5:0] cfg_osel = 0;
    logic [1:0] cfg_start_sel = 0, cfg_stop_sel = 0, cfg_sclk_sel = 0;
    logic cfg_sclk_en = 0, cfg_bp_en = 0;
    logic sw_start = 0, ana_cmp = 0, freq_in = 0, int_sclk = 0, eoa_req = 0;
    logic [1:0] line_in = 0;
    logic [1:0] line_oe, line_out;
    logic start_pulse, stop_pulse, eoa_pulse, samp_clk, bp_sclk;

    int n_chk = 0, n_fail = 0;
    bit mon_on = 0;

    trig_line_router dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_dir(cfg_dir),
        .cfg_osel(cfg_osel), .cfg_start_sel(cfg_start_sel),
        .cfg_stop_sel(cfg_stop_sel), .cfg_sclk_sel(cfg_sclk_sel),
        .cfg_sclk_en(cfg_sclk_en), .cfg_bp_en(cfg_bp_en), .sw_start(sw_start),
        .ana_cmp(ana_cmp), .freq_in(freq_in), .int_sclk(int_sclk),
        .eoa_req(eoa_req), .line_in(line_in), .line_oe(line_oe),
        .line_out(line_out), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .eoa_pulse(eoa_pulse), .samp_clk(samp_clk), .bp_sclk(bp_sclk)
    );

    always #2 clk = ~clk;

    // ---------------- reference model ----------------
    int m_dir [2], m_osel [2], q1 [2], q2 [2], pv [2];
    int m_ssel, m_psel, m_csel, m_sen, m_bp, m_anap, m_sclkp;
    int st_left, sp_left, eo_left;

    function automatic int m_rx(int i);
        return m_dir[i] ? 0 : q2[i];
    endfunction
    function automatic int m_sclk();
        if (m_csel >= 2) return m_rx(m_csel - 2);
        return int'(int_sclk);
    endfunction
    function automatic int m_ev(int sel, int sw_ok);
        if (sel == 0) return sw_ok ? int'(sw_start) : 0;
        if (sel == 1) return (ana_cmp && !m_anap) ? 1 : 0;
        return (!m_dir[sel-2] && q2[sel-2] && !pv[sel-2]) ? 1 : 0;
    endfunction
    function automatic int m_out(int i);
        if (!m_dir[i]) return 0;
        case (m_osel[i])
            0: return 0;
            1: return 1;
            2: return st_left > 0;
            3: return sp_left > 0;
            4: return eo_left > 0;
            5: return m_sen ? m_sclk() : 1;
            6: return int'(ana_cmp);
            default: return int'(freq_in);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_dir[i] = 0; m_osel[i] = 0; q1[i] = 0; q2[i] = 0; pv[i] = 0;
            end
            m_ssel = 0; m_psel = 0; m_csel = 0; m_sen = 0; m_bp = 0;
            m_anap = 0; m_sclkp = 0; st_left = 0; sp_left = 0; eo_left = 0;
        end else begin
            int sev, pev, sc, sr;
            sev = m_ev(m_ssel, 1);
            pev = m_ev(m_psel, 0);
            sc  = m_sclk();
            sr  = sc && !m_sclkp;
            if (st_left > 0) st_left--; else if (sev != 0) st_left = TRIG;
            if (sp_left > 0) sp_left--; else if (pev != 0) sp_left = TRIG;
            if (sr != 0) begin
                if (eo_left > 0) eo_left--; else if (eoa_req) eo_left = EOAP;
            end
            m_sclkp = sc;
            m_anap  = int'(ana_cmp);
            for (int i = 0; i < 2; i++) begin
                pv[i] = q2[i]; q2[i] = q1[i]; q1[i] = int'(line_in[i]);
            end
            if (cfg_load) begin
                for (int i = 0; i < 2; i++) begin
                    m_dir[i]  = int'(cfg_dir[i]);
                    m_osel[i] = int'(cfg_osel[3*i +: 3]);
                end
                m_ssel = cfg_start_sel; m_psel = cfg_stop_sel; m_csel = cfg_sclk_sel;
                m_sen = cfg_sclk_en; m_bp = cfg_bp_en;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input int exp);
        n_chk++;
        if (act !== 8'(exp)) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // Compare every output with the model at the falling edge.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            chk("R1 line_oe", 8'(line_oe), m_dir[0] + 2*m_dir[1]);
            chk("R2 line_out", 8'(line_out), m_out(0) + 2*m_out(1));
            chk("R3 start_pulse", 8'(start_pulse), st_left > 0);
            chk("R4 stop_pulse", 8'(stop_pulse), sp_left > 0);
            chk("R6 eoa_pulse", 8'(eoa_pulse), eo_left > 0);
            chk("R7 samp_clk", 8'(samp_clk), m_sclk());
            chk("R8 bp_sclk", 8'(bp_sclk), m_bp ? m_sclk() : 0);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic load(input logic [1:0] d, input logic [5:0] os, input logic [1:0] ss,
                        input logic [1:0] ps, input logic [1:0] cs, input logic se,
                        input logic be);
        cfg_dir = d; cfg_osel = os; cfg_start_sel = ss; cfg_stop_sel = ps;
        cfg_sclk_sel = cs; cfg_sclk_en = se; cfg_bp_en = be; cfg_load = 1;
        step();
        cfg_load = 0;
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary.
    initial begin
        #(4 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) step();
        @(negedge clk);
        chk("R1 reset oe", 8'(line_oe), 0);
        chk("R8 reset bp_sclk", 8'(bp_sclk), 0);
        chk("R3 reset start", 8'(start_pulse), 0);
        step();
        rst_n = 1;
        mon_on = 1;
        step();
        // R9: config inputs without the strobe change nothing
        cfg_dir = 2'b11; cfg_bp_en = 1;
        step(); step();
        @(negedge clk);
        chk("R9 no load oe", 8'(line_oe), 0);
        // line0 drives start pulse, line1 drives stop pulse
        load(2'b11, {3'd3, 3'd2}, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0);
        // R5: back-to-back software requests
        sw_start = 1; step();
        @(negedge clk); chk("R5 first high", 8'(start_pulse), 1);
        step(); sw_start = 0;
        @(negedge clk); chk("R5 second high", 8'(start_pulse), 1);
        chk("R4 no sw stop", 8'(stop_pulse), 0);
        step();
        @(negedge clk); chk("R5 no extend", 8'(start_pulse), 0);
        // analog source for start and stop
        load(2'b11, {3'd3, 3'd2}, 2'd1, 2'd1, 2'd0, 1'b1, 1'b1);
        repeat (4) begin ana_cmp = ~ana_cmp; step(); step(); step(); end
        // line1 input as start and sample clock; line0 drives sample clock
        load(2'b01, {3'd0, 3'd5}, 2'd3, 2'd3, 2'd3, 1'b1, 1'b1);
        for (int k = 0; k < 40; k++) begin
            line_in[1] = (k % 6) < 3;
            eoa_req = (k == 10);
            step();
        end
        eoa_req = 0;
        // Random phase
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(7) == 0) sw_start = 1; else sw_start = 0;
            if ($urandom_range(5) == 0) ana_cmp = ~ana_cmp;
            if ($urandom_range(3) == 0) freq_in = ~freq_in;
            if (k % 3 == 0) int_sclk = ~int_sclk;
            eoa_req = ($urandom_range(9) == 0);
            if ($urandom_range(4) == 0) line_in[$urandom_range(1)] ^= 1'b1;
            if ($urandom_range(39) == 0)
                load(2'($urandom), 6'($urandom), 2'($urandom), 2'($urandom),
                     2'($urandom), 1'($urandom), 1'($urandom));
            else
                step();
        end
        mon_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule